// File: doc/BRIEF.md
# Asynchronous SRAM Write Sequencer

This block turns single-word write requests from a clocked host into a correctly timed write on an asynchronous 32K x 8 static RAM. The host offers a 15-bit address and an 8-bit word with a request/ready handshake. The block then produces the memory's active-low chip select, write enable and output enable, its address bus, and the data word with a separate drive enable. The pad ring turns that enable into the tri-state bus.

Two parameters set the timing: the speed grade (45 ns or 70 ns cycle) and the clock period in picoseconds. At elaboration, each minimum interval of the grade becomes a whole number of cycles, rounded up. Every interval that is not zero gets at least one cycle.

The memory write runs in a fixed order:
- Address and data go out with both strobes high.
- Both strobes fall in the same cycle.
- Write enable rises first, and that edge ends the write.
- Chip select rises one cycle later.
- Address and data are held one more cycle.
- A recovery stretch follows when the minimum cycle time has not yet passed.

Top module: `sram_wr_seq`

## Requirements
- R1: After reset, wr_ready is 1, mem_cs_n, mem_we_n and mem_oe_n are 1, and mem_dout_en is 0.
- R2: A request is accepted on a rising clock edge where wr_req and wr_ready are both 1. wr_ready is 0 in the next cycle. The accepted address and word are on mem_addr and mem_dout when the write ends.
- R3: Address and data are driven (mem_dout_en = 1) one cycle before the strobes go active. mem_cs_n and mem_we_n fall in the same cycle.
- R4: Both strobes stay low together for exactly L cycles. L is the largest of the cycle counts for chip-select-to-end, address-to-end, write pulse width and data-to-end.
- R5: The write is ended by mem_we_n rising while mem_cs_n is still 0. mem_cs_n rises exactly one cycle later.
- R6: mem_addr and mem_dout stay unchanged and driven from the setup cycle through the cycle after chip select rises.
- R7: mem_oe_n is 1 at all times.
- R8: mem_dout_en is 0 whenever wr_ready is 1.
- R9: Each accepted request holds wr_ready at 0 for exactly max(C_wc, L + 3) cycles, so back-to-back requests cannot shorten the cycle. C_wc is the cycle count for the minimum write cycle.
- R10: Each limit is converted as ceil(limit_ps / CLK_PERIOD_PS). The limits in ns, for grade 0 and grade 1, are:
  - cycle: 45 / 70
  - chip select to end: 35 / 60
  - address to end: 25 / 60
  - write pulse: 25 / 55
  - data to end: 20 / 30
  - address hold: 1 / 1

  Each strobe-low time and each address/data stable time before the end is at least its converted limit.
- R11: Changes on wr_addr, wr_data and wr_req while wr_ready is 0 do not alter the write in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_req | input | 1 | Host write request |
| wr_addr | input | ADDR_W | Host write address |
| wr_data | input | DATA_W | Host write word |
| wr_ready | output | 1 | Block idle, request will be taken |
| mem_cs_n | output | 1 | Memory chip select, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_oe_n | output | 1 | Memory output enable, held high |
| mem_addr | output | ADDR_W | Memory address bus |
| mem_dout | output | DATA_W | Data toward the memory |
| mem_dout_en | output | 1 | Drive enable for the data bus |

## Verification
The bench builds three copies of the block:
- Fast grade at a 4000 ps period. This gives L = 9 and a 12-cycle busy window.
- Slow grade at the same period. This gives L = 15 and an 18-cycle busy window.
- Fast grade at a 1000 ps period. This gives L = 35 and a 45-cycle window. It is the only setting where the recovery stretch is not empty, because the cycle-time limit exceeds the strobe path.

Each copy receives a sweep of walking-one and walking-zero addresses, plus all-zero and all-one words, alternating back-to-back and spaced requests. Every measured interval is compared with ceiling divisions computed in the bench.

// File: rtl/sram_wr_pkg.sv
package sram_wr_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SETUP,
      ST_STROBE,
      ST_END,
      ST_HOLD,
      ST_RECOVER
   } wr_state_e;

   typedef enum int {
      LIM_CYCLE,
      LIM_CS_END,
      LIM_ADDR_END,
      LIM_WE_PULSE,
      LIM_DATA_END,
      LIM_ADDR_HOLD
   } wr_limit_e;

   // Minimum interval in picoseconds for a grade (0 = 45 ns part, 1 = 70 ns part).
   function automatic int limit_ps(input int grade, input wr_limit_e which);
      int v;
      case (which)
         LIM_CYCLE:     v = (grade == 0) ? 45000 : 70000;
         LIM_CS_END:    v = (grade == 0) ? 35000 : 60000;
         LIM_ADDR_END:  v = (grade == 0) ? 25000 : 60000;
         LIM_WE_PULSE:  v = (grade == 0) ? 25000 : 55000;
         LIM_DATA_END:  v = (grade == 0) ? 20000 : 30000;
         LIM_ADDR_HOLD: v = 1000;
         default:       v = 0;
      endcase
      return v;
   endfunction

   // Round up to whole cycles; any positive limit yields at least one.
   function automatic int ps_to_cyc(input int lim, input int period);
      if (lim <= 0) return 0;
      return (lim + period - 1) / period;
   endfunction

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sram_wr_fsm.sv
module sram_wr_fsm
   import sram_wr_pkg::*;
#(
   parameter int STROBE_C = 1,
   parameter int HOLD_C   = 1,
   parameter int REC_C    = 0
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      start,
   output wr_state_e state_d,
   output logic      idle
);

   localparam int MAX_C = max2(max2(STROBE_C, HOLD_C), max2(REC_C, 1));
   localparam int CNT_W = $clog2(MAX_C + 1);

   wr_state_e        state_q;
   wr_state_e        after_hold;
   logic [CNT_W-1:0] cnt_q, cnt_d;

   generate
      if (REC_C > 0) begin : g_rec
         assign after_hold = ST_RECOVER;
      end else begin : g_norec
         assign after_hold = ST_IDLE;
      end
   endgenerate

   always_comb begin
      state_d = state_q;
      cnt_d   = (cnt_q != '0) ? cnt_q - 1'b1 : cnt_q;
      case (state_q)
         ST_IDLE: begin
            if (start) begin
               state_d = ST_SETUP;
               cnt_d   = '0;
            end
         end
         ST_SETUP: begin
            if (cnt_q == '0) begin
               state_d = ST_STROBE;
               cnt_d   = CNT_W'(STROBE_C - 1);
            end
         end
         ST_STROBE: begin
            if (cnt_q == '0) begin
               state_d = ST_END;
               cnt_d   = '0;
            end
         end
         ST_END: begin
            state_d = ST_HOLD;
            cnt_d   = CNT_W'(HOLD_C - 1);
         end
         ST_HOLD: begin
            if (cnt_q == '0) begin
               state_d = after_hold;
               cnt_d   = (REC_C > 0) ? CNT_W'(REC_C - 1) : '0;
            end
         end
         ST_RECOVER: begin
            if (cnt_q == '0) state_d = ST_IDLE;
         end
         default: begin
            state_d = ST_IDLE;
            cnt_d   = '0;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
      end else begin
         state_q <= state_d;
         cnt_q   <= cnt_d;
      end
   end

   assign idle = (state_q == ST_IDLE);

endmodule

// File: rtl/sram_wr_pins.sv
module sram_wr_pins
   import sram_wr_pkg::*;
#(
   parameter int ADDR_W = 15,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic [DATA_W-1:0] data_in,
   input  wr_state_e         state_d,
   output logic              cs_n,
   output logic              we_n,
   output logic              oe_n,
   output logic [ADDR_W-1:0] addr,
   output logic [DATA_W-1:0] dout,
   output logic              dout_en
);

   logic cs_n_d, we_n_d, en_d;

   always_comb begin
      cs_n_d = !(state_d inside {ST_STROBE, ST_END});
      we_n_d = (state_d != ST_STROBE);
      en_d   = state_d inside {ST_SETUP, ST_STROBE, ST_END, ST_HOLD};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_n    <= 1'b1;
         we_n    <= 1'b1;
         oe_n    <= 1'b1;
         dout_en <= 1'b0;
         addr    <= '0;
         dout    <= '0;
      end else begin
         cs_n    <= cs_n_d;
         we_n    <= we_n_d;
         oe_n    <= 1'b1;
         dout_en <= en_d;
         if (load) begin
            addr <= addr_in;
            dout <= data_in;
         end
      end
   end

endmodule

// File: rtl/sram_wr_seq.sv
module sram_wr_seq
   import sram_wr_pkg::*;
#(
   parameter int SPEED_GRADE   = 0,
   parameter int CLK_PERIOD_PS = 10000,
   parameter int ADDR_W        = 15,
   parameter int DATA_W        = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_req,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              wr_ready,
   output logic              mem_cs_n,
   output logic              mem_we_n,
   output logic              mem_oe_n,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_dout,
   output logic              mem_dout_en
);

   localparam int WC_C  = ps_to_cyc(limit_ps(SPEED_GRADE, LIM_CYCLE),     CLK_PERIOD_PS);
   localparam int SCS_C = ps_to_cyc(limit_ps(SPEED_GRADE, LIM_CS_END),    CLK_PERIOD_PS);
   localparam int AW_C  = ps_to_cyc(limit_ps(SPEED_GRADE, LIM_ADDR_END),  CLK_PERIOD_PS);
   localparam int PWE_C = ps_to_cyc(limit_ps(SPEED_GRADE, LIM_WE_PULSE),  CLK_PERIOD_PS);
   localparam int SD_C  = ps_to_cyc(limit_ps(SPEED_GRADE, LIM_DATA_END),  CLK_PERIOD_PS);
   localparam int HA_C  = ps_to_cyc(limit_ps(SPEED_GRADE, LIM_ADDR_HOLD), CLK_PERIOD_PS);

   localparam int STROBE_C = max2(max2(SCS_C, AW_C), max2(PWE_C, max2(SD_C, 1)));
   localparam int HOLD_C   = max2(HA_C, 1);
   localparam int PATH_C   = 2 + STROBE_C + HOLD_C;
   localparam int REC_C    = (WC_C > PATH_C) ? WC_C - PATH_C : 0;

   generate
      if (SPEED_GRADE != 0 && SPEED_GRADE != 1) begin : g_bad_grade
         $error("SPEED_GRADE must be 0 or 1");
      end
      if (CLK_PERIOD_PS < 1) begin : g_bad_period
         $error("CLK_PERIOD_PS must be positive");
      end
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("ADDR_W and DATA_W must be positive");
      end
   endgenerate

   wr_state_e state_d;
   logic      idle;
   logic      start;

   assign start    = wr_req && idle;
   assign wr_ready = idle;

   sram_wr_fsm #(
      .STROBE_C (STROBE_C),
      .HOLD_C   (HOLD_C),
      .REC_C    (REC_C)
   ) u_fsm (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .state_d (state_d),
      .idle    (idle)
   );

   sram_wr_pins #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_pins (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (start),
      .addr_in (wr_addr),
      .data_in (wr_data),
      .state_d (state_d),
      .cs_n    (mem_cs_n),
      .we_n    (mem_we_n),
      .oe_n    (mem_oe_n),
      .addr    (mem_addr),
      .dout    (mem_dout),
      .dout_en (mem_dout_en)
   );

endmodule

// File: rtl/sram_wr_seq_chk.sv
module sram_wr_seq_chk #(
   parameter int ADDR_W = 15,
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_req,
   input logic              wr_ready,
   input logic              mem_cs_n,
   input logic              mem_we_n,
   input logic              mem_oe_n,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [DATA_W-1:0] mem_dout,
   input logic              mem_dout_en
);

   // R2
   accept_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_req && wr_ready |=> !wr_ready);

   // R3
   strobes_fall_together_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_we_n) |-> $fell(mem_cs_n));

   // R3
   data_before_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_cs_n) |-> $past(mem_dout_en));

   // R5
   we_ends_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> !mem_cs_n);

   // R5
   cs_after_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_cs_n) |-> $past(mem_we_n));

   // R6
   addr_stable_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_cs_n || !mem_we_n) |-> ($stable(mem_addr) && $stable(mem_dout) && mem_dout_en));

   // R6
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_cs_n) |-> ($stable(mem_addr) && $stable(mem_dout) && mem_dout_en));

   // R7
   oe_high_chk: assert property (@(posedge clk) disable iff (!rst_n) mem_oe_n);

   // R8
   idle_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ready |-> !mem_dout_en);

endmodule

bind sram_wr_seq sram_wr_seq_chk #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .wr_req      (wr_req),
   .wr_ready    (wr_ready),
   .mem_cs_n    (mem_cs_n),
   .mem_we_n    (mem_we_n),
   .mem_oe_n    (mem_oe_n),
   .mem_addr    (mem_addr),
   .mem_dout    (mem_dout),
   .mem_dout_en (mem_dout_en)
);

// File: tb/tb_sram_port.sv
module tb_sram_port #(
   parameter int GRADE = 0,
   parameter int PER   = 4000
) (
   input  logic clk,
   input  logic rst_n,
   output logic done,
   output int   nvec,
   output int   nfail
);

   localparam int NW = 32;

   function automatic int cdiv(input int a, input int b);
      return (a + b - 1) / b;
   endfunction

   localparam int WC_PS  = (GRADE == 0) ? 45000 : 70000;
   localparam int SCS_PS = (GRADE == 0) ? 35000 : 60000;
   localparam int AW_PS  = (GRADE == 0) ? 25000 : 60000;
   localparam int PWE_PS = (GRADE == 0) ? 25000 : 55000;
   localparam int SD_PS  = (GRADE == 0) ? 20000 : 30000;

   localparam int E_SCS = cdiv(SCS_PS, PER);
   localparam int E_AW  = cdiv(AW_PS, PER);
   localparam int E_PWE = cdiv(PWE_PS, PER);
   localparam int E_SD  = cdiv(SD_PS, PER);
   localparam int E_L0  = (E_SCS > E_AW) ? E_SCS : E_AW;
   localparam int E_L1  = (E_PWE > E_SD) ? E_PWE : E_SD;
   localparam int EL    = (E_L0 > E_L1) ? E_L0 : E_L1;
   localparam int EB    = (cdiv(WC_PS, PER) > EL + 3) ? cdiv(WC_PS, PER) : EL + 3;

   logic        req, rdy, cs_n, we_n, oe_n, en;
   logic [14:0] wa, ma;
   logic [7:0]  wd, md;

   sram_wr_seq #(
      .SPEED_GRADE   (GRADE),
      .CLK_PERIOD_PS (PER),
      .ADDR_W        (15),
      .DATA_W        (8)
   ) dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_req      (req),
      .wr_addr     (wa),
      .wr_data     (wd),
      .wr_ready    (rdy),
      .mem_cs_n    (cs_n),
      .mem_we_n    (we_n),
      .mem_oe_n    (oe_n),
      .mem_addr    (ma),
      .mem_dout    (md),
      .mem_dout_en (en)
   );

   logic [14:0] qa[$];
   logic [7:0]  qd[$];

   // Stimulus: walking-one / walking-zero addresses, alternating spacing.
   initial begin
      req  = 1'b0;
      wa   = '0;
      wd   = '0;
      done = 1'b0;
      wait (rst_n);
      repeat (3) @(negedge clk);
      for (int i = 0; i < NW; i++) begin
         logic [14:0] pa;
         logic [7:0]  pd;
         if (i < 15)       pa = 15'(1) << i;
         else if (i == 15) pa = 15'h0000;
         else if (i == 16) pa = 15'h7fff;
         else              pa = 15'h7fff ^ (15'(1) << (i - 17));
         if (i == 15)      pd = 8'h00;
         else if (i == 16) pd = 8'hff;
         else              pd = 8'(i * 29 + 7) ^ 8'(i << 4);
         req = 1'b1;
         wa  = pa;
         wd  = pd;
         while (!rdy) @(negedge clk);
         qa.push_back(pa);
         qd.push_back(pd);
         @(negedge clk);
         // R11: disturb the inputs while busy
         wa = ~pa;
         wd = ~pd;
         if (i % 2 == 1) begin
            req = 1'b0;
            repeat (3) @(negedge clk);
         end
      end
      req = 1'b0;
      while (qa.size() != 0) @(negedge clk);
      repeat (EB + 4) @(negedge clk);
      done = 1'b1;
   end

   logic        seen, p_cs, p_we, p_rdy, p_en, post;
   logic [14:0] p_a, h_a;
   logic [7:0]  p_d, h_d;
   int          cs_run, we_run, ovl_run, a_stab, d_stab, busy;

   task automatic chk(input bit ok, input string tag, input int got, input int expv);
      nvec++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s (grade %0d, period %0d ps): got %0h expected %0h",
                  tag, GRADE, PER, got, expv);
      end
   endtask

   initial begin
      nvec  = 0;
      nfail = 0;
   end

   always @(negedge clk) begin
      if (!rst_n) begin
         seen = 1'b0; post = 1'b0;
         p_cs = 1'b1; p_we = 1'b1; p_rdy = 1'b1; p_en = 1'b0;
         p_a = '0; p_d = '0; h_a = '0; h_d = '0;
         cs_run = 0; we_run = 0; ovl_run = 0; a_stab = 0; d_stab = 0; busy = 0;
      end else begin
         if (!seen) begin
            seen = 1'b1;
            // R1
            chk(rdy && cs_n && we_n && oe_n && !en, "R1 reset state",
                {rdy, cs_n, we_n, oe_n, en}, 5'b11110);
         end
         if (post) begin
            post = 1'b0;
            chk(cs_n && we_n, "R5 cs rises one cycle after we", {cs_n, we_n}, 2'b11);
            chk(en && ma == h_a && md == h_d, "R6 hold after end", {en, ma, md},
                {1'b1, h_a, h_d});
         end
         if (p_cs && p_we && (!cs_n || !we_n)) begin
            chk(!cs_n && !we_n, "R3 strobes fall together", {cs_n, we_n}, 2'b00);
            chk(p_en && en && ma == p_a && md == p_d, "R3 setup cycle", {p_en, en}, 2'b11);
         end
         if (!p_cs && !p_we && !(!cs_n && !we_n)) begin
            chk(we_n && !cs_n, "R5 we ends write", {cs_n, we_n}, 2'b01);
            chk(ovl_run == EL, "R4 strobe overlap", ovl_run, EL);
            chk(cs_run * PER >= SCS_PS, "R10 cs to end", cs_run, E_SCS);
            chk(we_run * PER >= PWE_PS, "R10 we pulse", we_run, E_PWE);
            chk(a_stab * PER >= AW_PS, "R10 address to end", a_stab, E_AW);
            chk(d_stab * PER >= SD_PS, "R10 data to end", d_stab, E_SD);
            chk(oe_n, "R7 oe high", oe_n, 1);
            if (qa.size() == 0) begin
               chk(1'b0, "R2 unexpected write", ma, 0);
            end else begin
               chk(p_a == qa[0], "R2/R11 address written", p_a, qa[0]);
               chk(p_d == qd[0], "R2/R11 data written", p_d, qd[0]);
               void'(qa.pop_front());
               void'(qd.pop_front());
            end
            h_a = ma;
            h_d = md;
            post = 1'b1;
         end
         if (rdy && !p_rdy) begin
            chk(busy == EB, "R9 busy window", busy, EB);
            chk(!en, "R8 no drive when ready", en, 0);
         end
         busy    = rdy ? 0 : busy + 1;
         cs_run  = !cs_n ? cs_run + 1 : 0;
         we_run  = !we_n ? we_run + 1 : 0;
         ovl_run = (!cs_n && !we_n) ? ovl_run + 1 : 0;
         a_stab  = (ma == p_a) ? a_stab + 1 : 1;
         d_stab  = (en && p_en && md == p_d) ? d_stab + 1 : (en ? 1 : 0);
         p_cs  = cs_n;
         p_we  = we_n;
         p_rdy = rdy;
         p_en  = en;
         p_a   = ma;
         p_d   = md;
      end
   end

endmodule

// File: tb/tb_sram_wr_seq.sv
`timescale 1ns/1ps
module tb_sram_wr_seq;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic d0, d1, d2;
   int   v0, v1, v2, f0, f1, f2;
   int   cyc = 0;

   always @(posedge clk) cyc <= cyc + 1;

   tb_sram_port #(.GRADE(0), .PER(4000)) u_fast (
      .clk (clk), .rst_n (rst_n), .done (d0), .nvec (v0), .nfail (f0));
   tb_sram_port #(.GRADE(1), .PER(4000)) u_slow (
      .clk (clk), .rst_n (rst_n), .done (d1), .nvec (v1), .nfail (f1));
   tb_sram_port #(.GRADE(0), .PER(1000)) u_rec (
      .clk (clk), .rst_n (rst_n), .done (d2), .nvec (v2), .nfail (f2));

   initial begin
      int wd_fail;
      wd_fail = 0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      while (!(d0 && d1 && d2) && cyc < 150000) @(negedge clk);
      if (!(d0 && d1 && d2)) begin
         wd_fail = 1;
         $display("FAIL watchdog: got %0d cycles expected completion", cyc);
      end
      $display("== %0d vectors applied, %0d miscompares ==",
               v0 + v1 + v2 + wd_fail, f0 + f1 + f2 + wd_fail);
      $finish;
   end

endmodule